// File: doc/BRIEF.md
# Quadrature Position Decoder with Skip Recovery

This block turns the two phase signals of an incremental encoder into a signed position count. Both phases are brought into the system clock domain through two-flop synchronizers. On every clock the synchronized pair is compared with the pair stored on the previous clock, and the count moves by -2, -1, 0, +1 or +2. When both phases flip between two samples, the block does not drop the movement. It assumes the missing edges belonged to phase A and applies a fixed double step.

After reset the block waits a settle interval, counted in clock cycles, so that external RC filters on the phase lines can charge. At the end of that interval it takes the phase pair as its starting reference and raises `ready`. Counting begins only from that point. A host can overwrite the count with a load strobe at any time.

Top module: `qdec_position`

## Requirements
- R1: While reset is asserted and on release, `position` is 0 and `ready` is 0.
- R2: `ready` rises exactly SETTLE_CYCLES rising edges after reset release and then stays high. Until then, phase activity never changes `position`.
- R3: On the cycle `ready` rises, the synchronized phase pair becomes the reference. A later change is counted against that reference.
- R4: With the transition index formed as {new B, new A, old B, old A} (old A in bit 0), indices 1, 7, 8 and 14 add one to `position`.
- R5: Indices 2, 4, 11 and 13 subtract one.
- R6: Indices 0, 5, 10 and 15 (no phase change) leave `position` unchanged.
- R7: Indices 3 and 12 add two. Indices 6 and 9 subtract two.
- R8: After each evaluation the stored reference becomes the new phase pair, so consecutive double and single steps accumulate correctly.
- R9: `load_en` high at a rising edge sets `position` to `load_val`. If a step is evaluated on the same edge, the load wins. The phase pair of that step still becomes the reference.
- R10: `position` wraps modulo 2^32 in two's complement: 0x7FFFFFFF+1 gives 0x80000000 and 0-1 gives 0xFFFFFFFF.
- R11: A phase change applied to the pins shows up in `position` after the third rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| load_en | input | 1 | Overwrite strobe for the count |
| load_val | input | POS_W | Value written on a load |
| position | output | POS_W | Signed position count |
| ready | output | 1 | High once the starting reference is captured |

## Verification
The hardest case to reach is a load that lands on the same clock edge as a step evaluation. The stimulus changes the phases on a falling edge and then raises `load_en` exactly two falling edges later, so that the load and the evaluation share the third rising edge. The next ordinary step then shows whether the reference was still updated. Double steps come from moving both phase inputs on the same falling edge. That is impossible with a real encoder at low speed, but it is trivial to drive at the pins.

// File: rtl/qdec_position.sv
module qdec_position #(
  parameter int POS_W         = 32,
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_val,
  output logic [POS_W-1:0] position,
  output logic             ready
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic             a_meta, a_sync, b_meta, b_sync;
  logic [1:0]       ref_q;
  logic [CNT_W-1:0] settle_q;
  logic             ready_q;
  logic [POS_W-1:0] pos_q;
  logic [3:0]       idx;
  logic signed [2:0] step;
  logic [POS_W-1:0] pos_next;

  assign idx = {b_sync, a_sync, ref_q};

  always_comb begin
    case (idx)
      4'd1, 4'd7, 4'd8, 4'd14:  step = 3'sd1;
      4'd2, 4'd4, 4'd11, 4'd13: step = -3'sd1;
      4'd3, 4'd12:              step = 3'sd2;
      4'd6, 4'd9:               step = -3'sd2;
      default:                  step = 3'sd0;
    endcase
  end

  assign pos_next = pos_q + {{(POS_W-3){step[2]}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_meta <= 1'b0;
      a_sync <= 1'b0;
      b_meta <= 1'b0;
      b_sync <= 1'b0;
    end else begin
      a_meta <= phase_a;
      a_sync <= a_meta;
      b_meta <= phase_b;
      b_sync <= b_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      ready_q  <= 1'b0;
      ref_q    <= 2'b00;
    end else if (!ready_q) begin
      if (settle_q == CNT_LAST) begin
        ready_q <= 1'b1;
        ref_q   <= {b_sync, a_sync};
      end else begin
        settle_q <= settle_q + 1'b1;
      end
    end else begin
      ref_q <= {b_sync, a_sync};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos_q <= '0;
    else if (load_en)
      pos_q <= load_val;
    else if (ready_q)
      pos_q <= pos_next;
  end

  assign position = pos_q;
  assign ready    = ready_q;

endmodule

module qdec_position_chk #(
  parameter int POS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [POS_W-1:0] load_val,
  input logic [POS_W-1:0] position,
  input logic             ready
);

  localparam logic [POS_W-1:0] ONE  = POS_W'(1);
  localparam logic [POS_W-1:0] TWO  = POS_W'(2);
  localparam logic [POS_W-1:0] MONE = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] MTWO = {{(POS_W-1){1'b1}}, 1'b0};

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !load_en) |=> $stable(position));

  // R2
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (position == $past(load_val)));

  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load_en) |=>
      ((position - $past(position)) == '0  || (position - $past(position)) == ONE ||
       (position - $past(position)) == TWO || (position - $past(position)) == MONE ||
       (position - $past(position)) == MTWO));

  // R1
  always @(posedge clk)
    if (!rst_n) reset_state_chk: assert (position == '0 && !ready);

endmodule

bind qdec_position qdec_position_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
  .position(position), .ready(ready)
);

// File: tb/test_qdec_position.sv
module test_qdec_position;
  localparam int W = 32;
  localparam int SETTLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0;
  logic load_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] position;
  logic ready;

  always #2 clk = ~clk;

  qdec_position #(.POS_W(W), .SETTLE_CYCLES(SETTLE)) i_qdec_position (
    .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb),
    .load_en(load_en), .load_val(load_val), .position(position), .ready(ready));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic [W-1:0] model_pos = '0;
  logic [1:0] model_ref = 2'b00;

  task automatic record(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ord(input logic [1:0] ba);
    case (ba)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int delta(input logic [1:0] old_ba, input logic [1:0] new_ba);
    int d;
    d = (ord(new_ba) - ord(old_ba) + 4) % 4;
    if (d == 1) return 1;
    if (d == 3) return -1;
    if (d == 2) return (old_ba[0] == old_ba[1]) ? 2 : -2;
    return 0;
  endfunction

  // monitor: compare queued expectations against the port
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      record(position === e, t, position, e);
    end
  end

  task automatic push(input string tag);
    exp_q.push_back(model_pos);
    tag_q.push_back(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic step_to(input logic b, input logic a, input string tag);
    @(negedge clk);
    model_pos = model_pos + W'(delta(model_ref, {b, a}));
    model_ref = {b, a};
    pa = a; pb = b;
    repeat (4) @(negedge clk);
    push(tag);
  endtask

  task automatic load(input logic [W-1:0] v, input string tag);
    @(negedge clk);
    load_en = 1'b1; load_val = v;
    @(negedge clk);
    load_en = 1'b0;
    model_pos = v;
    @(negedge clk);
    push(tag);
  endtask

  task automatic load_with_step(input logic b, input logic a, input logic [W-1:0] v, input string tag);
    @(negedge clk);
    pa = a; pb = b;
    repeat (2) @(negedge clk);
    load_en = 1'b1; load_val = v;
    @(negedge clk);
    load_en = 1'b0;
    model_pos = v;
    model_ref = {b, a};
    repeat (3) @(negedge clk);
    push(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    record(position === '0, "R1 reset position", position, '0);
    record(ready === 1'b0, "R1 reset ready", W'(ready), '0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pa = ~pa;
      if (i % 2 == 1) pb = ~pb;
    end
    pa = 1'b1; pb = 1'b1;
    repeat (SETTLE - 12) @(negedge clk);
    record(ready === 1'b0, "R2 ready low during settle", W'(ready), '0);
    record(position === '0, "R2 no count during settle", position, '0);
    repeat (12) @(negedge clk);
    record(ready === 1'b1, "R2 ready high after settle", W'(ready), 1);
    model_ref = 2'b11;

    step_to(1, 1, "R3 reference held");
    step_to(1, 0, "R3 first step from captured reference");

    // R11 latency
    @(negedge clk);
    pb = 1'b1; pa = 1'b1;
    repeat (2) @(negedge clk);
    record(position === model_pos, "R11 unchanged after two edges", position, model_pos);
    @(negedge clk);
    record(position === model_pos + 1, "R11 updated after third edge", position, model_pos + 1);
    model_pos = model_pos + 1; model_ref = 2'b11;

    step_to(0, 1, "R4 forward 11->01");
    step_to(0, 0, "R4 forward 01->00");
    step_to(1, 0, "R4 forward 00->10");
    step_to(1, 1, "R4 forward 10->11");
    step_to(1, 0, "R5 reverse 11->10");
    step_to(0, 0, "R5 reverse 10->00");
    step_to(0, 1, "R5 reverse 00->01");
    step_to(1, 1, "R5 reverse 01->11");
    step_to(1, 1, "R6 hold 11");
    step_to(1, 0, "R5 reverse 11->10");
    step_to(1, 0, "R6 hold 10");
    step_to(0, 1, "R7 double index 6");
    step_to(1, 0, "R7 double index 9");
    step_to(1, 1, "R8 single after doubles");
    step_to(0, 0, "R7 double index 3");
    step_to(1, 1, "R7 double index 12");
    step_to(1, 0, "R8 reference follows pair");

    load(32'h0000_1234, "R9 plain load");
    load_with_step(1, 1, 32'h0000_5000, "R9 load wins over step");
    step_to(0, 1, "R9 reference updated under load");

    load(32'h7FFF_FFFF, "R9 load max");
    step_to(0, 0, "R10 wrap positive");
    load(32'h0000_0000, "R9 load zero");
    step_to(0, 1, "R10 wrap negative");
    load(32'h8000_0001, "R9 load near min");
    step_to(1, 0, "R10 double wrap");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule